// File: doc/BRIEF.md
# Auto-Ranging Frequency Counter

The block measures the rate of an already synchronised digital input by counting its rising edges over a fixed gate window. The window is derived from the system clock. The result is a 3-3/4 digit BCD reading with full scale 3999. A decade prescaler sits in front of the BCD counter. After each gate the prescaler is moved up when the count overflows the display range, and moved down when the count is too small to use the digits. The decimal-point select follows the active decade, so with a 1 s gate the reading is in Hz, kHz with two, one or no fractional digits.

A display latch downstream takes the reading, the decimal-point select and the overrange flag. It loads them on a one-cycle update strobe. Peak hold freezes the decade and keeps the largest reading seen. Probe mode leaves the counter and ranging running but freezes everything the display sees.

Top module: `freq_autorange_counter`

## Requirements
- R1: A gate lasts GATE_LEN clock cycles (default 40000). The gates follow each other with no gap, starting from reset. The cycle that closes a gate evaluates the result, and an input edge in that cycle is not counted. Prescaler and counter restart from zero for the next gate.
- R2: One count event is a rising edge of freq_i: low in one sampled cycle, high in the next.
- R3: With decade index k (0..3 by default), the prescaler passes one tick per 10^k edges. The reading is floor(edges/10^k) as packed BCD, least significant digit in bits [3:0].
- R4: dp_sel_o is 3 minus the decade index the loaded reading was taken in: 3 for 0..3999 Hz, 2 for 4..39.99 kHz, 1 for 40..399.9 kHz, 0 (no point) from 400 kHz.
- R5: If the ticks exceed full scale (3999 by default), the gate's reading is discarded and no strobe is issued. Without peak hold and below the top decade, the next gate uses one decade higher.
- R6: An overflowing gate that cannot step up (top decade, or peak hold on) sets ovr_o. Any gate that completes without overflow clears it. A gate that steps up also clears it.
- R7: If a gate completes without overflow with a reading below 400 (default) and the decade is above 0, the reading is shown and the next gate uses one decade lower. Peak hold blocks this step.
- R8: update_o is a one-cycle pulse in the cycle after a gate closes without overflow. digits_o and dp_sel_o change only with it.
- R9: While peak_hold_i is high the decade never changes. A non-overflow reading is loaded only if it is numerically greater than the reading shown.
- R10: While probe_mode_i is high at gate close, counting and ranging proceed, but update_o stays low and digits_o, dp_sel_o and ovr_o keep their values.
- R11: After reset: digits_o is 0, dp_sel_o is 3, ovr_o and update_o are 0, and the decade is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | 1 | Synchronised input to be counted |
| peak_hold_i | input | 1 | Keep largest reading, freeze decade |
| probe_mode_i | input | 1 | Suppress display output while counting |
| digits_o | output | 4*DIGITS | Packed BCD reading |
| dp_sel_o | output | 2 | Decimal-point select (3..0) |
| ovr_o | output | 1 | Overrange flag |
| update_o | output | 1 | Display latch load strobe |

## Verification
The assertions assume that freq_i is already synchronous to clk_i, and that mode inputs change between clock edges like any other synchronous signal. The bench drives freq_i, peak_hold_i and probe_mode_i only on falling edges, so no mode change can land on a sampling edge. The bench scales the gate to 1000 cycles, uses two digits and two decades. With these settings, input periods of 2 to 100 cycles reach overflow at both decades, underflow, and the in-range cases within a few gates. Input period and mode changes fall mid-gate on purpose, so mixed-rate gates are also covered.

// File: rtl/freq_ctr_pkg.sv
package freq_ctr_pkg;

  function automatic int pow10(input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  // BCD pattern of the full-scale reading: top digit = top, others 9
  function automatic logic [63:0] full_pattern(input int digits, input int top);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < digits - 1; i++) p[4*i +: 4] = 4'd9;
    p[4*(digits-1) +: 4] = 4'(top);
    return p;
  endfunction

endpackage

// File: rtl/fc_gate_timer.sv
module fc_gate_timer #(
  parameter int GATE_LEN = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_end_o
);
  localparam int CW = $clog2(GATE_LEN);
  localparam logic [CW-1:0] LAST = CW'(GATE_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign gate_end_o = (cnt_q == LAST);

  // R1
  gate_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end_o |=> (cnt_q == '0 && !gate_end_o));

endmodule

// File: rtl/fc_prescaler.sv
module fc_prescaler
  import freq_ctr_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int RW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          freq_i,
  input  logic [RW-1:0] range_i,
  output logic          tick_o
);
  localparam int PW = $clog2(pow10(NUM_RANGES - 1) + 1);

  logic          freq_q;
  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;
  logic          rise;

  assign lim  = PW'(pow10(int'(range_i)) - 1);
  assign rise = freq_i & ~freq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      freq_q <= freq_i;
      if (clr_i)     pre_q <= '0;
      else if (rise) pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
    end
  end

  assign tick_o = rise & (pre_q == lim) & ~clr_i;

  // R3
  presc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= lim);

endmodule

// File: rtl/fc_bcd_counter.sv
module fc_bcd_counter
  import freq_ctr_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter int TOP_MAX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [4*DIGITS-1:0] count_o,
  output logic              ovf_o
);
  localparam int DW = 4 * DIGITS;
  localparam logic [DW-1:0] FULL = DW'(full_pattern(DIGITS, TOP_MAX));

  logic              ovf_q;
  logic              full;
  logic [DIGITS-1:0] carry;

  assign full     = (count_o == FULL);
  assign carry[0] = tick_i & ~ovf_q & ~full & ~clr_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       d_q <= '0;
      else if (clr_i)    d_q <= '0;
      else if (carry[i]) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
    end
    assign count_o[4*i +: 4] = d_q;
    if (i < DIGITS - 1) begin : g_c
      assign carry[i+1] = carry[i] & (d_q == 4'd9);
    end
    // R3
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      d_q <= 4'd9);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (clr_i)           ovf_q <= 1'b0;
    else if (tick_i && full)  ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

  // R5
  full_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o[DW-1 -: 4] <= 4'(TOP_MAX));

endmodule

// File: rtl/freq_autorange_counter.sv
module freq_autorange_counter #(
  parameter int GATE_LEN   = 40000,
  parameter int DIGITS     = 4,
  parameter int TOP_MAX    = 3,
  parameter int NUM_RANGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                freq_i,
  input  logic                peak_hold_i,
  input  logic                probe_mode_i,
  output logic [4*DIGITS-1:0] digits_o,
  output logic [1:0]          dp_sel_o,
  output logic                ovr_o,
  output logic                update_o
);
  localparam int DW = 4 * DIGITS;
  localparam int RW = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;
  localparam logic [RW-1:0] TOP_RANGE = RW'(NUM_RANGES - 1);

  logic          gate_end, tick, ovf;
  logic [DW-1:0] cnt;
  logic [RW-1:0] range_q;
  logic [DW-1:0] disp_q;
  logic [1:0]    dp_q;
  logic          ovr_q, upd_q;
  logic          low, step_up, step_dn, load;

  fc_gate_timer #(.GATE_LEN(GATE_LEN)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_end_o(gate_end)
  );

  fc_prescaler #(.NUM_RANGES(NUM_RANGES), .RW(RW)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(gate_end), .freq_i(freq_i),
    .range_i(range_q), .tick_o(tick)
  );

  fc_bcd_counter #(.DIGITS(DIGITS), .TOP_MAX(TOP_MAX)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(gate_end), .tick_i(tick),
    .count_o(cnt), .ovf_o(ovf)
  );

  // below (TOP_MAX+1) in the second digit with an empty top digit
  assign low     = (cnt[DW-1 -: 4] == 4'd0) && (cnt[DW-5 -: 4] < 4'(TOP_MAX + 1));
  assign step_up = ovf & ~peak_hold_i & (range_q != TOP_RANGE);
  assign step_dn = ~ovf & low & ~peak_hold_i & (range_q != '0);
  assign load    = ~ovf & ~probe_mode_i & (~peak_hold_i | (cnt > disp_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q <= '0;
      disp_q  <= '0;
      dp_q    <= 2'd3;
      ovr_q   <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (gate_end) begin
        if (step_up)      range_q <= range_q + 1'b1;
        else if (step_dn) range_q <= range_q - 1'b1;
        if (load) begin
          disp_q <= cnt;
          dp_q   <= 2'd3 - 2'(range_q);
          upd_q  <= 1'b1;
        end
        if (!probe_mode_i) ovr_q <= ovf & ~step_up;
      end
    end
  end

  assign digits_o = disp_q;
  assign dp_sel_o = dp_q;
  assign ovr_o    = ovr_q;
  assign update_o = upd_q;

  // R1
  range_at_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end |=> $stable(range_q));
  // R8
  update_after_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ($past(gate_end) && !$past(ovf)));
  // R8
  update_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);
  // R4
  dp_follows_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (dp_sel_o == 2'd3 - 2'($past(range_q))));
  // R9
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_hold_i |=> $stable(range_q));
  // R9
  hold_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && $past(peak_hold_i)) |-> (digits_o > $past(digits_o)));
  // R10
  probe_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_mode_i |=> (!update_o && $stable(ovr_o)));
  // R6
  ovr_at_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($past(gate_end) && $past(ovf)));

endmodule

// File: tb/freq_autorange_counter_test.sv
module freq_autorange_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int GL = 1000;
  localparam int D  = 2;
  localparam int TM = 3;
  localparam int NR = 2;
  localparam int DW = 4 * D;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic freq_i = 1'b0;
  logic peak_hold_i = 1'b0;
  logic probe_mode_i = 1'b0;
  logic [DW-1:0] digits_o;
  logic [1:0] dp_sel_o;
  logic ovr_o, update_o;

  int total = 0, bad = 0;
  int period = 0, ph = 0;
  int upd_seen = 0;
  bit comparing = 0, finished = 0;

  freq_autorange_counter #(.GATE_LEN(GL), .DIGITS(D), .TOP_MAX(TM), .NUM_RANGES(NR)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .freq_i(freq_i), .peak_hold_i(peak_hold_i),
    .probe_mode_i(probe_mode_i), .digits_o(digits_o), .dp_sel_o(dp_sel_o),
    .ovr_o(ovr_o), .update_o(update_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int p10(input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r *= 10;
    return r;
  endfunction

  function automatic logic [DW-1:0] to_bcd(input int v);
    logic [DW-1:0] b = '0;
    for (int i = 0; i < D; i++) begin
      b[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return b;
  endfunction

  localparam int FS   = (TM + 1) * p10(D - 1) - 1;
  localparam int LOWV = (TM + 1) * p10(D - 2);

  // behavioural reference
  int m_pos, m_edges, m_rng, m_shown, m_dp, m_t;
  bit m_prev, m_ovr, m_upd, m_of, m_step;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pos = 0; m_edges = 0; m_rng = 0; m_shown = 0; m_dp = 3;
      m_prev = 0; m_ovr = 0; m_upd = 0;
    end else begin
      m_upd = 0;
      if (m_pos == GL - 1) begin
        m_t = m_edges / p10(m_rng);
        m_of = (m_t > FS);
        m_step = m_of && !peak_hold_i && (m_rng < NR - 1);
        if (m_of) begin
          if (!probe_mode_i) m_ovr = !m_step;
          if (m_step) m_rng++;
        end else begin
          if (!probe_mode_i) begin
            m_ovr = 0;
            if (!peak_hold_i || m_t > m_shown) begin
              m_shown = m_t; m_dp = 3 - m_rng; m_upd = 1;
            end
          end
          if (!peak_hold_i && m_rng > 0 && m_t < LOWV) m_rng--;
        end
        m_edges = 0; m_pos = 0;
      end else begin
        if (freq_i && !m_prev) m_edges++;
        m_pos++;
      end
      m_prev = freq_i;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stimulus generator: square wave of 'period' cycles, 0 = held low
  always @(negedge clk_i) begin
    if (period == 0) freq_i <= 1'b0;
    else begin
      if (ph >= period) ph = 0;
      freq_i <= (ph < period / 2);
      ph = ph + 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && comparing) begin
      if (update_o) upd_seen++;
      chk("R3", "digits", 32'(digits_o), 32'(to_bcd(m_shown)));
      chk("R4", "dp_sel", 32'(dp_sel_o), 32'(m_dp));
      chk("R6", "ovr", 32'(ovr_o), 32'(m_ovr));
      chk("R8", "update", 32'(update_o), 32'(m_upd));
    end
  end

  task automatic gates(input int n);
    repeat (n * GL) @(negedge clk_i);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    logic [DW-1:0] d1;
    int u0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11", "digits", 32'(digits_o), 0);
    chk("R11", "dp_sel", 32'(dp_sel_o), 3);
    chk("R11", "ovr", 32'(ovr_o), 0);
    chk("R11", "update", 32'(update_o), 0);
    rst_ni = 1'b1;
    comparing = 1;
    // R1: first gate closes at cycle GL
    repeat (GL - 1) @(negedge clk_i);
    chk("R1", "update before gate end", 32'(update_o), 0);
    @(negedge clk_i);
    chk("R1", "update at gate end", 32'(update_o), 1);

    // R2, R3: in-range at decade 0
    period = 50;
    gates(3);
    u0 = upd_seen;
    gates(3);
    chk("R8", "strobes per 3 gates", 32'(upd_seen - u0), 3);
    chk("R2", "count at period 50", 32'(digits_o), 32'(to_bcd(m_shown)));
    chk("R4", "dp decade 0", 32'(dp_sel_o), 3);

    // R5: overflow steps up
    period = 10;
    gates(4);
    chk("R5", "dp after step up", 32'(dp_sel_o), 2);
    chk("R5", "ovr after step up", 32'(ovr_o), 0);

    // R6: overflow at top decade
    period = 2;
    gates(3);
    chk("R6", "ovr at top", 32'(ovr_o), 1);
    chk("R6", "dp unchanged", 32'(dp_sel_o), 2);

    // R7: underflow steps down
    period = 100;
    gates(4);
    chk("R7", "dp after step down", 32'(dp_sel_o), 3);
    chk("R7", "ovr cleared", 32'(ovr_o), 0);

    // R9: peak hold keeps largest reading
    period = 40;
    gates(3);
    peak_hold_i = 1'b1;
    period = 100;
    gates(1);
    d1 = digits_o;
    u0 = upd_seen;
    gates(3);
    chk("R9", "held digits", 32'(digits_o), 32'(d1));
    chk("R9", "no strobes on lower", 32'(upd_seen - u0), 0);
    period = 10;
    gates(3);
    chk("R9", "decade frozen dp", 32'(dp_sel_o), 3);
    chk("R9", "overflow flags ovr", 32'(ovr_o), 1);

    // R10: probe mode mutes display
    peak_hold_i = 1'b0;
    probe_mode_i = 1'b1;
    period = 50;
    d1 = digits_o;
    u0 = upd_seen;
    gates(3);
    chk("R10", "no strobes", 32'(upd_seen - u0), 0);
    chk("R10", "digits frozen", 32'(digits_o), 32'(d1));
    chk("R10", "ovr frozen", 32'(ovr_o), 1);
    probe_mode_i = 1'b0;
    u0 = upd_seen;
    gates(3);
    chk("R10", "strobes resume", 32'(upd_seen - u0 > 0), 1);
    chk("R10", "ovr cleared after", 32'(ovr_o), 0);

    summary();
  end
endmodule